// File: doc/BRIEF.md
# Self-Calibrating Pulse-Width Nibble Receiver

This block pulls bytes out of a peripheral that answers each request with one low pulse whose width encodes four bits. For every nibble the block drops its request line. The peripheral then pulls the return line low. The block raises the request again as soon as it sees that falling edge, and it times the low phase until the rising edge. The time is counted in ticks of a fixed number of clocks, and the count saturates at the top of its range.

The decoder learns its own scale. In calibration mode the first byte the peripheral sends must be 0xF0. Its short pulse becomes the stored minimum width, and its long pulse fixes the span of widths that follows. After that, each data width is trimmed by one tick to allow for jitter and placed on one of 16 levels by a four-step binary search over the span. Two consecutive nibbles form one byte, low nibble first, and the byte is presented with a one-cycle strobe. A 16-bit length operand, equal to the byte count minus one, sets when the transfer stops.

A calibration that comes out implausible is reported as an error. The learned scale is then wiped, so the next transfer has to calibrate again.

Top module: `pw_nibble_rx`

## Requirements
- R1: After reset the request line is high, busy is low, and neither the byte strobe nor the error strobe is set.
- R2: A start in idle makes busy high and drives the request line low. The request goes high once the falling edge of the return line is seen, and it stays high while the return line is low. After the rising edge it goes low again, unless the transfer has finished.
- R3: Measured width = floor(L / 4), where L is the number of clock cycles the return line is low (TICK_DIV = 4). The width saturates at 255 instead of wrapping.
- R4: A start with calibration requested discards the stored scale. The first pulse then becomes the minimum width and the second pulse the maximum. Neither pulse produces a nibble or a byte.
- R5: If the maximum is below the minimum, or (maximum − minimum) >> 4 is zero, the error strobe pulses for one cycle. At the same time the block returns to idle with the request high and clears the stored minimum and span. A difference of exactly 16 is accepted.
- R6: A data width W is decoded from w = W − 1 (0 stays 0). If w < minimum, the nibble is 0. Otherwise d = w − minimum, lo = 0 and hi = maximum − minimum. Four steps follow, from bit 3 down to bit 0: mid = floor((lo + hi) / 2); if d ≥ mid the bit is 1 and lo = mid + 1; otherwise the bit is 0 and hi = mid − 1.
- R7: The first nibble of a pair is bits 3:0 of the byte and the second nibble is bits 7:4. The byte strobe is high for exactly one cycle after the second pulse ends.
- R8: A transfer delivers exactly length + 1 bytes, counted without the calibration pulses. Afterwards busy is low and the request line stays high.
- R9: A start while busy is ignored. The calibration flag and length given with it have no effect on the transfer in progress.
- R10: A start without calibration decodes the first pulse at once if a scale is stored. If no scale is stored, it first calibrates from two pulses as in R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a transfer (sampled in idle only) |
| calib_i | input | 1 | With start: discard the scale and calibrate first |
| len_i | input | 16 | With start: number of bytes minus one |
| ret_i | input | 1 | Return pulse line from the peripheral (asynchronous) |
| req_o | output | 1 | Request line, low asks for the next pulse |
| busy_o | output | 1 | Transfer in progress |
| byte_o | output | 8 | Assembled byte |
| byte_valid_o | output | 1 | One-cycle strobe for byte_o |
| err_o | output | 1 | One-cycle strobe on a calibration failure |

## Verification
A bad stored minimum or span shows up in the value of every byte decoded afterwards. It appears at the byte strobe about two pulses later. A miscounted width or a wrapped saturation changes the decoded nibble of the pulse that caused it. A wrong nibble-pair state or length counter shows up as swapped nibbles, extra or missing bytes, or busy falling at the wrong pulse. A scale that is not cleared after an error shows up when the next non-calibrating transfer emits a byte two pulses too early.

// File: rtl/pw_pkg.sv
package pw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_WAIT_FALL = 2'd1,
    ST_WAIT_RISE = 2'd2
  } rx_state_t;
endpackage

// File: rtl/pw_edge_sync.sv
module pw_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q[0] <= d_i;
      prev_q     <= chain_q[STAGES-1];
    end
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain_q[i] <= 1'b1;
      else     chain_q[i] <= chain_q[i-1];
    end
  end

  assign rise_o = chain_q[STAGES-1] & ~prev_q;
  assign fall_o = ~chain_q[STAGES-1] & prev_q;

  a_r2_edges_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(rise_o && fall_o));
endmodule

// File: rtl/pw_width_meter.sv
module pw_width_meter #(
  parameter int TICK_DIV = 4,
  parameter int W_BITS   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              run_i,
  output logic [W_BITS-1:0] width_o
);
  localparam int SUB_W = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(TICK_DIV - 1);
  localparam logic [W_BITS-1:0] W_MAX = '1;

  logic [SUB_W-1:0] sub_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sub_q   <= '0;
      width_o <= '0;
    end else if (clr_i) begin
      sub_q   <= SUB_W'(1);
      width_o <= '0;
    end else if (run_i) begin
      if (sub_q == SUB_LAST) begin
        sub_q <= '0;
        if (width_o != W_MAX) width_o <= width_o + 1'b1;
      end else begin
        sub_q <= sub_q + 1'b1;
      end
    end
  end

  a_r3_saturate_hold: assert property (@(posedge clk) disable iff (rst)
    (width_o == W_MAX && !clr_i) |=> (width_o == W_MAX));
  a_r3_no_step_over_one: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !$isunknown(width_o)) |=> (width_o == $past(width_o) || width_o == $past(width_o) + 1'b1));
endmodule

// File: rtl/pw_quantizer.sv
module pw_quantizer #(
  parameter int W_BITS = 8,
  parameter int STEPS  = 4
) (
  input  logic [W_BITS-1:0] width_i,
  input  logic [W_BITS-1:0] min_i,
  input  logic [W_BITS:0]   span_i,
  output logic [STEPS-1:0]  nib_o
);
  localparam int AW = W_BITS + 2;

  logic [AW-1:0] w_ext;
  logic [AW-1:0] d_ext;
  logic          below;
  logic [AW-1:0] lo  [STEPS];
  logic [AW-1:0] hi  [STEPS];
  logic [AW-1:0] mid [STEPS];
  logic          ge  [STEPS];

  always_comb begin
    w_ext = (width_i == '0) ? '0 : (AW'(width_i) - AW'(1));
    below = (w_ext < AW'(min_i));
    d_ext = w_ext - AW'(min_i);
  end

  assign lo[0] = '0;
  assign hi[0] = AW'(span_i) - AW'(1);

  for (genvar s = 0; s < STEPS; s++) begin : g_step
    assign mid[s] = (lo[s] + hi[s]) >> 1;
    assign ge[s]  = (d_ext >= mid[s]);
    assign nib_o[STEPS-1-s] = ~below & ge[s];
    if (s < STEPS - 1) begin : g_next
      assign lo[s+1] = ge[s] ? (mid[s] + AW'(1)) : lo[s];
      assign hi[s+1] = ge[s] ? hi[s] : (mid[s] - AW'(1));
    end
  end

  always_comb begin
    if (!below && span_i != '0 && d_ext >= AW'(span_i))
      a_r6_top_level: assert (nib_o == '1);
  end
endmodule

// File: rtl/pw_nibble_rx.sv
module pw_nibble_rx
  import pw_pkg::*;
#(
  parameter int TICK_DIV    = 4,
  parameter int W_BITS      = 8,
  parameter int NIB_BITS    = 4,
  parameter int LEN_BITS    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start_i,
  input  logic                  calib_i,
  input  logic [LEN_BITS-1:0]   len_i,
  input  logic                  ret_i,
  output logic                  req_o,
  output logic                  busy_o,
  output logic [2*NIB_BITS-1:0] byte_o,
  output logic                  byte_valid_o,
  output logic                  err_o
);
  rx_state_t              state_q;
  logic [LEN_BITS-1:0]    cnt_q;
  logic [W_BITS-1:0]      min_q;
  logic [W_BITS:0]        span_q;
  logic                   min_ok_q;
  logic                   have_low_q;
  logic [NIB_BITS-1:0]    low_q;
  logic                   rise, fall;
  logic [W_BITS-1:0]      width;
  logic [NIB_BITS-1:0]    nib;
  logic [W_BITS:0]        diff;
  logic                   cal_done;
  logic                   cal_bad;

  pw_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst(rst), .d_i(ret_i), .rise_o(rise), .fall_o(fall)
  );

  pw_width_meter #(.TICK_DIV(TICK_DIV), .W_BITS(W_BITS)) i_meter (
    .clk(clk), .rst(rst),
    .clr_i(state_q == ST_WAIT_FALL && fall),
    .run_i(state_q == ST_WAIT_RISE),
    .width_o(width)
  );

  pw_quantizer #(.W_BITS(W_BITS), .STEPS(NIB_BITS)) i_quant (
    .width_i(width), .min_i(min_q), .span_i(span_q), .nib_o(nib)
  );

  always_comb begin
    cal_done = (span_q != '0);
    diff     = {1'b0, width} - {1'b0, min_q};
    cal_bad  = (width < min_q) || ((diff >> NIB_BITS) == '0);
  end

  assign busy_o = (state_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      cnt_q        <= '0;
      min_q        <= '0;
      span_q       <= '0;
      min_ok_q     <= 1'b0;
      have_low_q   <= 1'b0;
      low_q        <= '0;
      req_o        <= 1'b1;
      byte_o       <= '0;
      byte_valid_o <= 1'b0;
      err_o        <= 1'b0;
    end else begin
      byte_valid_o <= 1'b0;
      err_o        <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            cnt_q      <= len_i;
            have_low_q <= 1'b0;
            if (calib_i) begin
              span_q   <= '0;
              min_q    <= '0;
              min_ok_q <= 1'b0;
            end
            req_o   <= 1'b0;
            state_q <= ST_WAIT_FALL;
          end
        end
        ST_WAIT_FALL: begin
          if (fall) begin
            req_o   <= 1'b1;
            state_q <= ST_WAIT_RISE;
          end
        end
        ST_WAIT_RISE: begin
          if (rise) begin
            req_o   <= 1'b0;
            state_q <= ST_WAIT_FALL;
            if (!cal_done) begin
              if (!min_ok_q) begin
                min_q    <= width;
                min_ok_q <= 1'b1;
              end else if (cal_bad) begin
                err_o    <= 1'b1;
                span_q   <= '0;
                min_q    <= '0;
                min_ok_q <= 1'b0;
                req_o    <= 1'b1;
                state_q  <= ST_IDLE;
              end else begin
                span_q <= diff + 1'b1;
              end
            end else if (!have_low_q) begin
              low_q      <= nib;
              have_low_q <= 1'b1;
            end else begin
              byte_o       <= {nib, low_q};
              byte_valid_o <= 1'b1;
              have_low_q   <= 1'b0;
              if (cnt_q == '0) begin
                req_o   <= 1'b1;
                state_q <= ST_IDLE;
              end else begin
                cnt_q <= cnt_q - 1'b1;
              end
            end
          end
        end
        default: begin
          req_o   <= 1'b1;
          state_q <= ST_IDLE;
        end
      endcase
    end
  end

  a_r1_req_high_when_idle: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> req_o);
  a_r2_req_high_during_pulse: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT_RISE) |-> req_o);
  a_r5_error_clears_scale: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (span_q == '0 && !min_ok_q && !busy_o));
  a_r7_strobe_single: assert property (@(posedge clk) disable iff (rst)
    byte_valid_o |=> !byte_valid_o);
  a_r4_no_byte_uncalibrated: assert property (@(posedge clk) disable iff (rst)
    byte_valid_o |-> cal_done);
endmodule

// File: tb/test_pw_nibble_rx.sv
module test_pw_nibble_rx;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic        calib_i = 1'b0;
  logic [15:0] len_i = '0;
  logic        ret_i = 1'b1;
  logic        req_o, busy_o, byte_valid_o, err_o;
  logic [7:0]  byte_o;

  int total = 0;
  int bad = 0;
  int err_cnt = 0;
  int cm = 0;
  int cM = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];

  always #2 clk = ~clk;

  pw_nibble_rx i_pw_nibble_rx (
    .clk(clk), .rst(rst), .start_i(start_i), .calib_i(calib_i), .len_i(len_i),
    .ret_i(ret_i), .req_o(req_o), .busy_o(busy_o), .byte_o(byte_o),
    .byte_valid_o(byte_valid_o), .err_o(err_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: scoreboard for bytes, counter for error strobes
  always @(negedge clk) begin
    if (!rst) begin
      if (byte_valid_o) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R4/R7 unexpected byte", byte_o, -1);
        end else begin
          automatic logic [7:0] e = exp_q.pop_front();
          check(byte_o == e, "R6/R7 byte value", byte_o, e);
        end
      end
      if (err_o) err_cnt++;
    end
  end

  // R6 model of the decoder
  function automatic logic [3:0] exp_nib(input int W);
    int w, d, lo, hi, mid;
    logic [3:0] n;
    w = (W > 255) ? 255 : W;
    w = (w == 0) ? 0 : w - 1;
    if (w < cm) return 4'h0;
    d = w - cm; lo = 0; hi = cM - cm; n = '0;
    for (int b = 3; b >= 0; b--) begin
      mid = (lo + hi) / 2;
      if (d >= mid) begin n[b] = 1'b1; lo = mid + 1; end
      else hi = mid - 1;
    end
    return n;
  endfunction

  task automatic begin_xfer(input bit cal, input int len);
    start_i = 1'b1; calib_i = cal; len_i = 16'(len);
    tick(1);
    start_i = 1'b0; calib_i = 1'b0;
  endtask

  // Peripheral model: one low pulse of 4*W+2 clocks per request
  task automatic pulse(input int W);
    while (req_o) tick(1);
    tick(3);
    ret_i = 1'b0;
    tick(8);
    check(req_o == 1'b1, "R2 request raised after fall", req_o, 1);
    tick(4 * W + 2 - 8);
    ret_i = 1'b1;
    tick(2);
  endtask

  task automatic data_byte(input int wlo, input int whi);
    exp_q.push_back({exp_nib(whi), exp_nib(wlo)});
    pulse(wlo);
    pulse(whi);
  endtask

  task automatic finish_check(input string tag);
    tick(8);
    check(busy_o == 1'b0, {tag, " busy low at end"}, busy_o, 0);
    check(req_o == 1'b1, {tag, " request high at end"}, req_o, 1);
    check(exp_q.size() == 0, {tag, " all bytes delivered"}, exp_q.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(5);
    rst = 1'b0;
    tick(1);
    // R1 reset state
    check(req_o == 1'b1, "R1 req after reset", req_o, 1);
    check(busy_o == 1'b0, "R1 busy after reset", busy_o, 0);
    check(byte_valid_o == 1'b0, "R1 strobe after reset", byte_valid_o, 0);
    check(err_o == 1'b0, "R1 error after reset", err_o, 0);

    // R4 calibrate with 0xF0, then three bytes (R6 below-min, R7, R8)
    begin_xfer(1'b1, 2);
    check(busy_o == 1'b1, "R2 busy after start", busy_o, 1);
    check(req_o == 1'b0, "R2 request low after start", req_o, 0);
    pulse(20); pulse(84);
    cm = 20; cM = 84;
    check(exp_q.size() == 0 && busy_o, "R4 calibration gives no byte, still busy", busy_o, 1);
    data_byte(22, 60);
    data_byte(40, 84);
    data_byte(10, 70);
    finish_check("R8");

    // R10 stored scale reused; R3 saturation (300 ticks -> 255 -> nibble F)
    begin_xfer(1'b0, 0);
    data_byte(55, 300);
    finish_check("R3/R10");

    // R9 start while busy ignored (calibrate flag and length)
    begin_xfer(1'b0, 1);
    exp_q.push_back({exp_nib(31), exp_nib(47)});
    pulse(47);
    begin_xfer(1'b1, 0);
    pulse(31);
    data_byte(66, 25);
    finish_check("R9");

    // R5 errors: max below min, then difference under 16
    begin_xfer(1'b1, 0);
    pulse(50); pulse(30);
    tick(4);
    check(err_cnt == 1, "R5 error on max below min", err_cnt, 1);
    check(busy_o == 1'b0, "R5 idle after error", busy_o, 0);
    begin_xfer(1'b1, 0);
    pulse(40); pulse(50);
    tick(4);
    check(err_cnt == 2, "R5 error on small range", err_cnt, 2);
    check(req_o == 1'b1, "R5 request high after error", req_o, 1);

    // R5/R10 scale cleared: non-calib start recalibrates; difference 16 accepted
    begin_xfer(1'b0, 0);
    pulse(30); pulse(46);
    cm = 30; cM = 46;
    check(err_cnt == 2, "R5 difference of 16 accepted", err_cnt, 2);
    data_byte(35, 44);
    finish_check("R10");
    check(err_cnt == 2, "R5 no spurious error", err_cnt, 2);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule